// File: doc/BRIEF.md
# Dual-Source Pixel Switcher

This block merges two pixel streams that share one dot clock into a single output stream. One source is a legacy display-adapter port that brings its own blanking signal. The other is a direct-color frame-buffer port with a separate blank. For every pixel, the block picks the source that drives the output. The choice comes from a port-select input, a rectangular window on the current pixel coordinates, or a masked color-key match against the legacy pixel.

The legacy stream can run in one of two timing modes. In externally clocked mode, legacy data, legacy blank and frame-buffer data arrive in the same cycle. In self-clocked mode, the legacy data and blank run three dot clocks ahead of the frame-buffer data. A delay line then holds them back so that both streams line up. When the timing mode changes, the aligned blank is forced active for three cycles, so that pixels from the old alignment never reach the output. All settings sit in a small write-only register set. The output pixel, blank and source flag are registered.

Top module: `vid_src_switch`

## Requirements
- R1: While reset is held, `out_pix` reads zero, `out_blank` reads 1 and `out_leg` reads 0. After reset every configuration register is zero. That means externally clocked timing, the legacy port disabled, all switching methods off and a 1:1 ratio.
- R2: A write with `cfg_we`=1 loads `cfg_wdata` into the register chosen by `cfg_addr`, and the value takes effect from the next cycle. The addresses are: 0 control, 1 window x start, 2 window x end, 3 window y start, 4 window y end, 5 key, 6 key mask. Control bit positions: [0] self-clocked timing (0 = externally clocked), [1] legacy port enable, [2] port-select enable, [3] window enable, [4] color-key enable, [6:5] multiplex ratio (0 = 1:1).
- R3: In externally clocked mode, the outputs sampled after a rising edge reflect the inputs of both ports presented in the cycle before that edge. This is one cycle of latency.
- R4: In self-clocked mode, the frame-buffer data, coordinates and select keep one cycle of latency. The legacy pixel and legacy blank used with them are those presented three cycles earlier.
- R5: With the legacy port disabled, the output carries the frame-buffer pixel, `out_blank` follows `pp_blank`, and `out_leg` is 0.
- R6: With the legacy port enabled and a ratio field other than 0, the frame-buffer port is always the source. Blanking still comes from the aligned legacy blank.
- R7: With the legacy port enabled, the ratio 1:1 and port-select enabled, `pp_sel`=1 picks the frame-buffer port and `pp_sel`=0 picks the legacy port. This holds whatever the window and color-key settings are.
- R8: With port-select disabled and the window enabled, the frame-buffer port is chosen exactly when x start ≤ `pix_x` ≤ x end and y start ≤ `pix_y` ≤ y end. Otherwise the legacy port is chosen.
- R9: With only the color key enabled, the frame-buffer port is chosen when (aligned legacy pixel AND mask) equals the key. Otherwise the legacy port is chosen.
- R10: With the legacy port enabled, the ratio 1:1 and no switching method enabled, the legacy port is the source.
- R11: Whenever `out_blank` is 1, `out_pix` is zero. `out_leg` is 1 exactly when the legacy port was the chosen source.
- R12: A write that changes control bit 0 forces the aligned legacy blank active for three cycles, starting with the cycle after the write edge. With the legacy port enabled, the three output samples that follow the next edge show `out_blank`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | CFG_W | Configuration write data |
| leg_pix | input | PIX_W | Legacy-port pixel |
| leg_blank | input | 1 | Legacy-port blank, active high |
| pp_pix | input | PIX_W | Frame-buffer-port pixel |
| pp_blank | input | 1 | Frame-buffer-port blank, used when the legacy port is off |
| pp_sel | input | 1 | Per-pixel port select, 1 = frame-buffer port |
| pix_x | input | CRD_W | Current pixel column |
| pix_y | input | CRD_W | Current pixel row |
| out_pix | output | PIX_W | Registered output pixel |
| out_blank | output | 1 | Registered output blank |
| out_leg | output | 1 | Registered flag: legacy port was the source |

## Verification
Some properties are checked on every cycle. These are the three-cycle delay of legacy data and blank in self-clocked mode, the zero pixel under blank, and the frame-buffer-only path while the legacy port is off. Also checked every cycle: the forced frame-buffer choice at non-1:1 ratios, the blank forced after a timing-mode change, and register loading. Other behaviours show up only in the bench's sweeps over coordinates, legacy pixel values and configurations. These are the priority among port-select, window and key, the inclusive window edges, and masked key matching. The exact cycle at which forced blanking starts and ends after a mode change is also shown only by the bench.

// File: rtl/vss_pkg.sv
package vss_pkg;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_WX0  = 3'd1;
  localparam logic [2:0] A_WX1  = 3'd2;
  localparam logic [2:0] A_WY0  = 3'd3;
  localparam logic [2:0] A_WY1  = 3'd4;
  localparam logic [2:0] A_KEY  = 3'd5;
  localparam logic [2:0] A_MASK = 3'd6;

  localparam int CTRL_W = 7;

  typedef struct packed {
    logic [1:0] ratio;
    logic       ckey_en;
    logic       win_en;
    logic       psel_en;
    logic       leg_en;
    logic       self_clk;
  } ctrl_t;

endpackage

// File: rtl/vss_cfg_regs.sv
module vss_cfg_regs
  import vss_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int CRD_W = 11,
  parameter int CFG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [CRD_W-1:0] wx0,
  output logic [CRD_W-1:0] wx1,
  output logic [CRD_W-1:0] wy0,
  output logic [CRD_W-1:0] wy1,
  output logic [PIX_W-1:0] key,
  output logic [PIX_W-1:0] mask,
  output logic             mode_chg
);

  logic ctrl_hit;
  assign ctrl_hit = we && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      wx0      <= '0;
      wx1      <= '0;
      wy0      <= '0;
      wy1      <= '0;
      key      <= '0;
      mask     <= '0;
      mode_chg <= 1'b0;
    end else begin
      mode_chg <= ctrl_hit && (wdata[0] != ctrl.self_clk);
      if (we) begin
        case (addr)
          A_CTRL:  ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
          A_WX0:   wx0  <= wdata[CRD_W-1:0];
          A_WX1:   wx1  <= wdata[CRD_W-1:0];
          A_WY0:   wy0  <= wdata[CRD_W-1:0];
          A_WY1:   wy1  <= wdata[CRD_W-1:0];
          A_KEY:   key  <= wdata[PIX_W-1:0];
          A_MASK:  mask <= wdata[PIX_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // R2
  key_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && we && addr == A_KEY) |-> key == $past(wdata[PIX_W-1:0]));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ctrl_hit) |-> ctrl == ctrl_t'($past(wdata[CTRL_W-1:0])));

endmodule

// File: rtl/vss_align_dly.sv
module vss_align_dly #(
  parameter int PIX_W  = 24,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             self_clk,
  input  logic             mode_chg,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_blank,
  output logic [PIX_W-1:0] al_pix,
  output logic             al_blank
);

  localparam int CNT_W = $clog2(STAGES + 1);
  localparam logic [CNT_W-1:0] HOLD = CNT_W'(STAGES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(STAGES);

  logic [PIX_W-1:0] st_pix   [STAGES];
  logic             st_blank [STAGES];
  logic [CNT_W-1:0] flush_cnt;
  logic [CNT_W-1:0] warm;
  logic             flushing;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          st_pix[i]   <= '0;
          st_blank[i] <= 1'b1;
        end else begin
          st_pix[i]   <= in_pix;
          st_blank[i] <= in_blank;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          st_pix[i]   <= '0;
          st_blank[i] <= 1'b1;
        end else begin
          st_pix[i]   <= st_pix[i-1];
          st_blank[i] <= st_blank[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_cnt <= '0;
      warm      <= '0;
    end else begin
      if (mode_chg)             flush_cnt <= HOLD;
      else if (flush_cnt != '0) flush_cnt <= flush_cnt - 1'b1;
      if (warm != FULL)         warm <= warm + 1'b1;
    end
  end

  assign flushing = mode_chg || (flush_cnt != '0);
  assign al_pix   = self_clk ? st_pix[STAGES-1] : in_pix;
  assign al_blank = flushing || (self_clk ? st_blank[STAGES-1] : in_blank);

  if (STAGES == 3) begin : g_chk3
    // R4
    self_delay_chk: assert property (@(posedge clk) disable iff (rst)
      (self_clk && !flushing && warm == FULL) |->
        (al_blank == $past(in_blank, 3) && al_pix == $past(in_pix, 3)));
  end

  // R12
  flush_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_cnt != '0) |-> al_blank);

endmodule

// File: rtl/vss_src_pick.sv
module vss_src_pick
  import vss_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int CRD_W = 11
) (
  input  ctrl_t            ctrl,
  input  logic [CRD_W-1:0] wx0,
  input  logic [CRD_W-1:0] wx1,
  input  logic [CRD_W-1:0] wy0,
  input  logic [CRD_W-1:0] wy1,
  input  logic [PIX_W-1:0] key,
  input  logic [PIX_W-1:0] mask,
  input  logic [CRD_W-1:0] pix_x,
  input  logic [CRD_W-1:0] pix_y,
  input  logic             pp_sel,
  input  logic [PIX_W-1:0] al_pix,
  output logic             use_leg
);

  logic in_win;
  logic key_hit;
  logic may_switch;

  assign in_win  = (pix_x >= wx0) && (pix_x <= wx1) &&
                   (pix_y >= wy0) && (pix_y <= wy1);
  assign key_hit = ((al_pix & mask) == key);
  assign may_switch = ctrl.leg_en && (ctrl.ratio == 2'd0);

  always_comb begin
    if (!may_switch)       use_leg = 1'b0;
    else if (ctrl.psel_en) use_leg = !pp_sel;
    else if (ctrl.win_en)  use_leg = !in_win;
    else if (ctrl.ckey_en) use_leg = !key_hit;
    else                   use_leg = 1'b1;
  end

  always_comb begin
    // R6
    ratio_force_chk: assert (!(ctrl.leg_en && ctrl.ratio != 2'd0) || !use_leg);
    // R5
    leg_off_pick_chk: assert (ctrl.leg_en || !use_leg);
  end

endmodule

// File: rtl/vid_src_switch.sv
module vid_src_switch
  import vss_pkg::*;
#(
  parameter int PIX_W       = 24,
  parameter int CRD_W       = 11,
  parameter int SELF_STAGES = 3,
  parameter int CFG_W       = (PIX_W > CRD_W) ?
                              ((PIX_W > CTRL_W) ? PIX_W : CTRL_W) :
                              ((CRD_W > CTRL_W) ? CRD_W : CTRL_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [PIX_W-1:0] leg_pix,
  input  logic             leg_blank,
  input  logic [PIX_W-1:0] pp_pix,
  input  logic             pp_blank,
  input  logic             pp_sel,
  input  logic [CRD_W-1:0] pix_x,
  input  logic [CRD_W-1:0] pix_y,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_blank,
  output logic             out_leg
);

  ctrl_t            ctrl;
  logic [CRD_W-1:0] wx0, wx1, wy0, wy1;
  logic [PIX_W-1:0] key, mask;
  logic             mode_chg;
  logic [PIX_W-1:0] al_pix;
  logic             al_blank;
  logic             use_leg;
  logic             blank_sel;

  vss_cfg_regs #(.PIX_W(PIX_W), .CRD_W(CRD_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .wx0(wx0), .wx1(wx1), .wy0(wy0), .wy1(wy1),
    .key(key), .mask(mask), .mode_chg(mode_chg)
  );

  vss_align_dly #(.PIX_W(PIX_W), .STAGES(SELF_STAGES)) u_dly (
    .clk(clk), .rst(rst), .self_clk(ctrl.self_clk), .mode_chg(mode_chg),
    .in_pix(leg_pix), .in_blank(leg_blank),
    .al_pix(al_pix), .al_blank(al_blank)
  );

  vss_src_pick #(.PIX_W(PIX_W), .CRD_W(CRD_W)) u_pick (
    .ctrl(ctrl), .wx0(wx0), .wx1(wx1), .wy0(wy0), .wy1(wy1),
    .key(key), .mask(mask), .pix_x(pix_x), .pix_y(pix_y),
    .pp_sel(pp_sel), .al_pix(al_pix), .use_leg(use_leg)
  );

  assign blank_sel = ctrl.leg_en ? al_blank : pp_blank;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_pix   <= '0;
      out_blank <= 1'b1;
      out_leg   <= 1'b0;
    end else begin
      out_blank <= blank_sel;
      out_leg   <= use_leg;
      out_pix   <= blank_sel ? '0 : (use_leg ? al_pix : pp_pix);
    end
  end

  // R11
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_blank |-> (out_pix == '0));

  // R5
  leg_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !ctrl.leg_en) |-> (out_blank == $past(pp_blank) && !out_leg));

  // R12
  flush_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mode_chg && ctrl.leg_en) |-> out_blank);

endmodule

// File: tb/vid_src_switch_bench.sv
module vid_src_switch_bench;

  localparam int PW = 8;
  localparam int CW = 3;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [FW-1:0] cfg_wdata = '0;
  logic [PW-1:0] leg_pix = '0;
  logic          leg_blank = 1'b0;
  logic [PW-1:0] pp_pix = '0;
  logic          pp_blank = 1'b1;
  logic          pp_sel = 1'b0;
  logic [CW-1:0] pix_x = '0;
  logic [CW-1:0] pix_y = '0;
  logic [PW-1:0] out_pix;
  logic          out_blank;
  logic          out_leg;

  vid_src_switch #(.PIX_W(PW), .CRD_W(CW), .SELF_STAGES(3), .CFG_W(FW)) u_vid_src_switch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .leg_pix(leg_pix), .leg_blank(leg_blank), .pp_pix(pp_pix), .pp_blank(pp_blank),
    .pp_sel(pp_sel), .pix_x(pix_x), .pix_y(pix_y),
    .out_pix(out_pix), .out_blank(out_blank), .out_leg(out_leg)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [PW-1:0] h_lp [8];
  logic [PW-1:0] h_pp [8];
  logic          h_lb [8];
  logic          h_pb [8];
  logic          h_sel[8];
  logic [CW-1:0] h_x  [8];
  logic [CW-1:0] h_y  [8];
  int k = 0;
  int g = 0;

  logic          s_self = 0, s_leg = 0, s_psel = 0, s_win = 0, s_ckey = 0;
  logic [1:0]    s_ratio = 0;
  logic [CW-1:0] s_wx0 = 0, s_wx1 = 0, s_wy0 = 0, s_wy1 = 0;
  logic [PW-1:0] s_key = 0, s_mask = 0;

  task automatic report(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [PW-1:0] lp, input logic lb, input logic [PW-1:0] pp,
                       input logic pb, input logic sel, input logic [CW-1:0] x,
                       input logic [CW-1:0] y);
    leg_pix = lp; leg_blank = lb; pp_pix = pp; pp_blank = pb;
    pp_sel = sel; pix_x = x; pix_y = y;
    h_lp[k%8] = lp; h_lb[k%8] = lb; h_pp[k%8] = pp; h_pb[k%8] = pb;
    h_sel[k%8] = sel; h_x[k%8] = x; h_y[k%8] = y;
    k++;
  endtask

  task automatic compare(input string req);
    int pi, li;
    logic e_blank, e_leg, hit, inw;
    logic [PW-1:0] lpx, e_pix;
    pi = (k - 1) % 8;
    li = (k - 1 - (s_self ? 3 : 0)) % 8;
    lpx = h_lp[li];
    inw = (h_x[pi] >= s_wx0) && (h_x[pi] <= s_wx1) && (h_y[pi] >= s_wy0) && (h_y[pi] <= s_wy1);
    hit = ((lpx & s_mask) == s_key);
    if (!s_leg) begin
      e_blank = h_pb[pi]; e_leg = 1'b0;
    end else begin
      e_blank = h_lb[li];
      if (s_ratio != 2'd0) e_leg = 1'b0;
      else if (s_psel)     e_leg = !h_sel[pi];
      else if (s_win)      e_leg = !inw;
      else if (s_ckey)     e_leg = !hit;
      else                 e_leg = 1'b1;
    end
    e_pix = e_blank ? '0 : (e_leg ? lpx : h_pp[pi]);
    report({req, " blank"}, int'(out_blank), int'(e_blank));
    report({req, " source"}, int'(out_leg), int'(e_leg));
    report({req, " R11 pixel"}, int'(out_pix), int'(e_pix));
  endtask

  task automatic step(input bit chk, input string req, input bit lp_seq);
    @(negedge clk);
    if (chk) compare(req);
    drive(lp_seq ? PW'(g) : PW'(g * 37 + 11), (g % 7) == 3, PW'(g * 53 + 7),
          (g % 5) == 1, g[1], CW'(g % 8), CW'((g / 8) % 8));
    g++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [FW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [FW-1:0] ctrl_word();
    return FW'({s_ratio, s_ckey, s_win, s_psel, s_leg, s_self});
  endfunction

  task automatic settle();
    for (int i = 0; i < 5; i++) step(1'b0, "", 1'b0);
  endtask

  task automatic sweep(input string req, input int n, input bit lp_seq);
    settle();
    for (int i = 0; i < n; i++) step(1'b1, req, lp_seq);
  endtask

  task automatic flush_test(input string req);
    // legacy blank held low and data steady; flip timing bit
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      drive(8'h5A, 1'b0, 8'hC3, 1'b0, 1'b0, '0, '0);
    end
    s_self = !s_self;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = ctrl_word();
    @(negedge clk);
    cfg_we = 1'b0;
    report({req, " pre-flush blank"}, int'(out_blank), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      report({req, " flush blank"}, int'(out_blank), 1);
    end
    @(negedge clk);
    report({req, " post-flush blank"}, int'(out_blank), 0);
    report({req, " post-flush pixel"}, int'(out_pix), 8'h5A);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) drive('0, 1'b1, '0, 1'b1, 1'b0, '0, '0);
    repeat (3) @(negedge clk);
    // R1 reset state
    report("R1 reset pixel", int'(out_pix), 0);
    report("R1 reset blank", int'(out_blank), 1);
    report("R1 reset source", int'(out_leg), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R5: reset config leaves legacy port off
    sweep("R1 R5", 40, 1'b0);

    // R2 window and key registers
    s_wx0 = 3'd2; s_wx1 = 3'd5; s_wy0 = 3'd1; s_wy1 = 3'd6;
    wr(3'd1, FW'(s_wx0)); wr(3'd2, FW'(s_wx1));
    wr(3'd3, FW'(s_wy0)); wr(3'd4, FW'(s_wy1));
    s_key = 8'h30; s_mask = 8'hF0;
    wr(3'd5, s_key); wr(3'd6, s_mask);

    // R3 R10: externally clocked, legacy default
    s_leg = 1; wr(3'd0, ctrl_word());
    sweep("R3 R10", 40, 1'b0);

    // R7: port select wins over window and key
    s_psel = 1; s_win = 1; s_ckey = 1; wr(3'd0, ctrl_word());
    sweep("R7", 40, 1'b0);

    // R8: inclusive window over all 64 coordinates
    s_psel = 0; s_ckey = 0; wr(3'd0, ctrl_word());
    sweep("R8", 64, 1'b0);

    // R9: key over every legacy pixel value
    s_win = 0; s_ckey = 1; wr(3'd0, ctrl_word());
    sweep("R9", 256, 1'b1);

    // R6: every non-1:1 ratio forces the frame-buffer port
    for (int r = 1; r < 4; r++) begin
      s_ratio = 2'(r); s_psel = 1; wr(3'd0, ctrl_word());
      sweep("R6", 30, 1'b0);
    end
    s_ratio = 0; s_psel = 0; s_ckey = 0; wr(3'd0, ctrl_word());
    settle();

    // R12: switch to self-clocked timing
    flush_test("R12 ext-to-self");

    // R4: self-clocked alignment with window and key
    s_win = 1; wr(3'd0, ctrl_word());
    sweep("R4 R8", 64, 1'b0);
    s_win = 0; s_ckey = 1; wr(3'd0, ctrl_word());
    sweep("R4 R9", 64, 1'b1);
    s_ckey = 0; wr(3'd0, ctrl_word());
    sweep("R4 R10", 30, 1'b0);

    // R12: switch back
    flush_test("R12 self-to-ext");
    sweep("R3", 30, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule